// File: doc/BRIEF.md
# Parameterized Processor Data Path

This block is the arithmetic core of a simple processor. A small register file with one write port and two read ports supplies two operands. The second operand passes through a barrel shifter. Both operands then feed an arithmetic/logic unit and a multiplier, which work side by side. A result multiplexer picks one of the two outputs. That result can be written back into the register file, or the register file can be loaded from an external data input instead.

An external controller drives every field of the control word on separate pins:
- the three register addresses and the write enable,
- the write-back source,
- the shift amount, direction and wrap mode,
- the ALU opcode,
- the product half select,
- the result select,
- the output enable.

The block returns two comparator flags. The final output drives the result onto a shared bus, or floats it.

Register reads are combinational. Writes land on the falling clock edge, so a controller that changes the control word just after each rising edge sees a complete read-compute-write in a single clock cycle.

Top module: `dp_core`

## Requirements
- R1: After `rst_n` is asserted, every register in the file reads as zero once reset has been released.
- R2: On the falling clock edge with `wr_en`=1, the register at `wr_addr` takes the write data. Both read ports show the new value from then on.
- R3: With `wr_en`=0, no register changes, whatever `wr_addr` and `data_in` hold.
- R4: `wb_sel`=0 selects `data_in` as the write data. `wb_sel`=1 selects the data path result.
- R5: Port A (`rd_addr_a`) gives operand A unshifted. Port B (`rd_addr_b`) gives operand B through the barrel shifter. The two addresses are independent.
- R6: The shifter moves operand B by `sh_amt` places. `sh_left`=1 shifts toward the MSB and `sh_left`=0 shifts toward the LSB. With `sh_rot`=1 the bits that leave one end re-enter at the other; with `sh_rot`=0 the vacated bits are zero.
- R7: `alu_op` selects the ALU result, truncated to the word width:
  - 0: A+B
  - 1: A-B
  - 2: A&B
  - 3: A|B
  - 4: A^B
  - 5: compare, result A-B
  - 6: A
  - 7: ~A
- R8: With `alu_op`=5, `flag_eq` = (A==B) and `flag_ge` = (A>=B), both unsigned, in the same cycle. For every other opcode both flags are 0.
- R9: With `res_sel`=1, the result is half of the double-width product A*B. `prod_hi`=0 selects the low half and `prod_hi`=1 the high half. With `res_sel`=0, the result is the ALU output.
- R10: With `out_en`=1, `data_out` drives the result. With `out_en`=0, every bit of `data_out` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register file writes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | WIDTH | External write data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW | Write register address |
| wb_sel | input | 1 | Write source: 0 data_in, 1 result |
| rd_addr_a | input | AW | Read address, port A |
| rd_addr_b | input | AW | Read address, port B (shifted operand) |
| sh_amt | input | clog2(WIDTH) | Shift distance |
| sh_left | input | 1 | 1 shift toward MSB, 0 toward LSB |
| sh_rot | input | 1 | 1 wrap bits around, 0 zero fill |
| alu_op | input | 3 | ALU opcode |
| prod_hi | input | 1 | Product half: 0 low, 1 high |
| res_sel | input | 1 | Result: 0 ALU, 1 multiplier |
| out_en | input | 1 | Output drive enable |
| data_out | output | WIDTH | Result onto a shared bus, high impedance when disabled |
| flag_eq | output | 1 | Compare: operands equal |
| flag_ge | output | 1 | Compare: A greater or equal B |

## Verification
Everything from the read addresses to `data_out` and the flags is combinational, so those results are due in the same cycle the control word is applied. The bench drives just after a rising edge and samples 4 ns later, well before the falling edge. A register write is due at the falling edge of the cycle that requests it. The bench checks it by reading the register back in the following cycle. For reset, the bench waits out the two-cycle reset synchronizer before it reads any register.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_PASS = 3'd6,
    OP_INV  = 3'd7
  } alu_op_e;

endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wr_sel;

  // write decoder: one clock enable per register
  always_comb begin
    wr_sel = '0;
    if (we) wr_sel[waddr] = 1'b1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_sel[i]) mem[i] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  a_r2_one_target: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  a_r2_write_lands: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we)) |-> mem[$past(waddr)] == $past(wdata));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
      a_r3_hold: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_sel[g])) |-> mem[g] == $past(mem[g]));
    end
  endgenerate

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(WIDTH)-1:0] amt,
  input  logic                     left,
  input  logic                     rot,
  output logic [WIDTH-1:0]         dout
);

  // WIDTH is expected to be a power of two
  localparam int SW = $clog2(WIDTH);

  logic [WIDTH-1:0] stage [SW+1];

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [WIDTH-1:0] moved;
      always_comb begin
        if (left) moved = rot ? ((stage[k] << S) | (stage[k] >> (WIDTH - S)))
                              : (stage[k] << S);
        else      moved = rot ? ((stage[k] >> S) | (stage[k] << (WIDTH - S)))
                              : (stage[k] >> S);
      end
      assign stage[k+1] = amt[k] ? moved : stage[k];
    end
  endgenerate

  assign dout = stage[SW];

  a_r6_rot_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rot |-> $countones(dout) == $countones(din));

  a_r6_fill_adds_no_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !rot |-> $countones(dout) <= $countones(din));

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] y,
  output logic             eq,
  output logic             ge
);
  import dp_pkg::*;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    unique case (op_e)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_CMP:  y = a - b;
      OP_PASS: y = a;
      OP_INV:  y = ~a;
      default: y = '0;
    endcase
  end

  always_comb begin
    eq = 1'b0;
    ge = 1'b0;
    if (op_e == OP_CMP) begin
      eq = (a == b);
      ge = (a >= b);
    end
  end

  a_r8_eq_implies_ge: assert property (@(posedge clk) disable iff (!rst_n)
    eq |-> ge);

  a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd5) |-> (!eq && !ge));

endmodule

// File: rtl/dp_core.sv
module dp_core #(
  parameter int WIDTH = 8,
  parameter int AW    = 2,
  parameter int SW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wb_sel,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  input  logic [SW-1:0]    sh_amt,
  input  logic             sh_left,
  input  logic             sh_rot,
  input  logic [2:0]       alu_op,
  input  logic             prod_hi,
  input  logic             res_sel,
  input  logic             out_en,
  output wire  [WIDTH-1:0] data_out,
  output logic             flag_eq,
  output logic             flag_ge
);

  localparam int PW = 2 * WIDTH;

  logic             rst_sync_n;
  logic [WIDTH-1:0] opa, opb_raw, opb;
  logic [WIDTH-1:0] alu_y, mul_y, result, wdata;
  logic [PW-1:0]    product;

  dp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dp_regfile #(.WIDTH(WIDTH), .AW(AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wdata),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (opa),
    .rdata_b (opb_raw)
  );

  dp_shifter #(.WIDTH(WIDTH)) u_sh (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (opb_raw),
    .amt   (sh_amt),
    .left  (sh_left),
    .rot   (sh_rot),
    .dout  (opb)
  );

  dp_alu #(.WIDTH(WIDTH)) u_alu (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .a     (opa),
    .b     (opb),
    .op    (alu_op),
    .y     (alu_y),
    .eq    (flag_eq),
    .ge    (flag_ge)
  );

  // multiplier alongside the ALU; one half of the product is forwarded
  assign product = PW'(opa) * PW'(opb);
  assign mul_y   = prod_hi ? product[PW-1:WIDTH] : product[WIDTH-1:0];

  assign result   = res_sel ? mul_y : alu_y;
  assign wdata    = wb_sel ? result : data_in;
  assign data_out = out_en ? result : {WIDTH{1'bz}};

endmodule

// File: tb/test_dp_core.sv
`timescale 1ns/1ps
module test_dp_core;

  localparam int W  = 8;
  localparam int AW = 2;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  data_in;
  logic          wr_en, wb_sel, sh_left, sh_rot, prod_hi, res_sel, out_en;
  logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b;
  logic [SW-1:0] sh_amt;
  logic [2:0]    alu_op;
  tri1  [W-1:0]  dout;
  logic          flag_eq, flag_ge;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dp_core #(.WIDTH(W), .AW(AW)) i_dp_core (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wb_sel(wb_sel), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .sh_amt(sh_amt), .sh_left(sh_left),
    .sh_rot(sh_rot), .alu_op(alu_op), .prod_hi(prod_hi),
    .res_sel(res_sel), .out_en(out_en), .data_out(dout),
    .flag_eq(flag_eq), .flag_ge(flag_ge)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wb_sel = 0; wr_addr = '0; data_in = '0;
    rd_addr_a = '0; rd_addr_b = '0; sh_amt = '0; sh_left = 0; sh_rot = 0;
    alu_op = 3'd6; prod_hi = 0; res_sel = 0; out_en = 1;
  endtask

  // one cycle: drive just after the rising edge, sample 4 ns later
  task automatic run(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                     input logic [SW-1:0] amt, input logic lf, input logic rt,
                     input logic [2:0] op, input logic hi, input logic rs);
    @(posedge clk); #1;
    idle();
    rd_addr_a = ra; rd_addr_b = rb; sh_amt = amt; sh_left = lf; sh_rot = rt;
    alu_op = op; prod_hi = hi; res_sel = rs;
    #4;
  endtask

  task automatic load(input logic [AW-1:0] addr, input logic [W-1:0] val);
    @(posedge clk); #1;
    idle();
    wr_en = 1; wr_addr = addr; data_in = val;
  endtask

  function automatic logic [W-1:0] shf(input logic [W-1:0] x, input int s,
                                       input logic lf, input logic rt);
    logic [W-1:0] y;
    for (int j = 0; j < W; j++) begin
      int src = lf ? j - s : j + s;
      if (src >= 0 && src < W) y[j] = x[src];
      else if (rt)             y[j] = x[(src + W) % W];
      else                     y[j] = 1'b0;
    end
    return y;
  endfunction

  function automatic logic [W-1:0] alu_ref(input int a, input int b, input int op);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a - b;
      6: r = a;
      default: r = ~a;
    endcase
    return W'(r);
  endfunction

  task automatic chk_zero_regs(input string req);
    for (int r = 0; r < (1 << AW); r++) begin
      run(AW'(r), AW'(r), '0, 0, 0, 3'd6, 0, 0);
      chk(req, dout, '0);
      run(2'd0, AW'(r), '0, 0, 0, 3'd0, 0, 0);
      chk(req, dout, '0);
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: all registers zero after reset, through both ports
    chk_zero_regs("R1");
    run(2'd0, 2'd0, '0, 0, 0, 3'd5, 0, 0);
    chk("R8 flags after reset eq", {7'd0, flag_eq}, 8'd1);

    // R2 R4: loads from data_in, visible on both ports the next cycle
    for (int r = 0; r < 4; r++) load(AW'(r), W'(8'h3C + 8'h21 * r));
    for (int r = 0; r < 4; r++) begin
      run(AW'(r), 2'd0, '0, 0, 0, 3'd6, 0, 0);
      chk("R2 port A", dout, W'(8'h3C + 8'h21 * r));
    end
    load(2'd0, 8'h00);
    for (int r = 1; r < 4; r++) begin
      run(2'd0, AW'(r), '0, 0, 0, 3'd0, 0, 0);
      chk("R2 port B", dout, W'(8'h3C + 8'h21 * r));
    end

    // R3: write disabled leaves r1 intact
    @(posedge clk); #1; idle(); wr_en = 0; wr_addr = 2'd1; data_in = 8'h5A;
    run(2'd1, 2'd1, '0, 0, 0, 3'd6, 0, 0);
    chk("R3 no write", dout, 8'h5D);

    // R1: reset again after writes
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk);
    chk_zero_regs("R1 re-reset");

    // R6: shifter sweep, operand A forced to zero, ADD passes shifted B
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat;
      pat = (p == 0) ? 8'h96 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : 8'hB3;
      load(2'd3, pat);
      for (int s = 0; s < W; s++)
        for (int m = 0; m < 4; m++) begin
          run(2'd0, 2'd3, SW'(s), m[0], m[1], 3'd0, 0, 0);
          chk("R6 shift", dout, shf(pat, s, m[0], m[1]));
        end
    end

    // R5 R7 R8 R9: operand sweep over ALU, compare flags and product halves
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 9; bi++) begin
        int a, b;
        a = (ai * 17) & 255;
        b = (bi == 8) ? a : ((bi * 37 + 5) & 255);
        load(2'd1, W'(a));
        load(2'd2, W'(b));
        for (int op = 0; op < 8; op++) begin
          run(2'd1, 2'd2, '0, 0, 0, 3'(op), 0, 0);
          chk("R7 alu", dout, alu_ref(a, b, op));
          chk("R8 eq", {7'd0, flag_eq}, {7'd0, (op == 5) && (a == b)});
          chk("R8 ge", {7'd0, flag_ge}, {7'd0, (op == 5) && (a >= b)});
        end
        run(2'd2, 2'd1, '0, 0, 0, 3'd1, 0, 0);
        chk("R5 swapped ports", dout, alu_ref(b, a, 1));
        run(2'd1, 2'd2, '0, 0, 0, 3'd0, 0, 1);
        chk("R9 product low", dout, W'((a * b) & 255));
        run(2'd1, 2'd2, '0, 0, 0, 3'd0, 1, 1);
        chk("R9 product high", dout, W'((a * b) >> 8));
      end

    // R4: write back the result, data_in carries a decoy
    load(2'd1, 8'h9A);
    load(2'd2, 8'h47);
    @(posedge clk); #1; idle();
    wr_en = 1; wb_sel = 1; wr_addr = 2'd3; data_in = 8'hEE;
    rd_addr_a = 2'd1; rd_addr_b = 2'd2; alu_op = 3'd0;
    run(2'd3, 2'd0, '0, 0, 0, 3'd6, 0, 0);
    chk("R4 result written", dout, 8'hE1);
    @(posedge clk); #1; idle();
    wr_en = 1; wb_sel = 1; wr_addr = 2'd3; data_in = 8'h11;
    rd_addr_a = 2'd1; rd_addr_b = 2'd2; res_sel = 1; prod_hi = 1;
    run(2'd3, 2'd0, '0, 0, 0, 3'd6, 0, 0);
    chk("R4 product high written", dout, W'((154 * 71) >> 8));

    // R10: output enable and float
    run(2'd0, 2'd0, '0, 0, 0, 3'd6, 0, 0);
    chk("R10 driven zero", dout, 8'h00);
    @(posedge clk); #1; idle(); out_en = 0; #4;
    chk("R10 floating", dout, 8'hFF);
    @(posedge clk); #1; idle(); out_en = 0; rd_addr_a = 2'd1; alu_op = 3'd7; #4;
    chk("R10 floating nonzero result", dout, 8'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule